// File: doc/BRIEF.md
# Byte-Port Command/Response Mailbox

This block is the device side of a two-address byte port through which a host exchanges framed command and response packets with an internal engine. Address 0 is the data port. Address 1 reads back a status byte and, when written, takes a command code. The host opens a frame with a command code, pushes command bytes one at a time through the data port while the input buffer is free, and closes the frame with an end code. The engine then returns a response through the same data port.

Framing is carried in-band. A marker flag in the status byte tells the host that the byte now in the data port is a frame code and not payload. A response therefore opens with a marker byte of 0x01, carries its payload bytes with the marker flag clear, and closes with a marker byte of 0x03. A cancel code returns the port to its ready state from any point. Re-opening a frame without a cancel first is also allowed and never locks the input-full flag.

On the engine side the block offers a valid/ready byte stream in each direction. It has a one-cycle end-of-command strobe and a one-cycle abort strobe. The engine drives a start-of-response strobe and an end-of-response strobe.

Top module: `cmdrsp_mailbox`

## Requirements
- R1: After reset the status byte reads 0x10, and cmd_valid_o, cmd_end_o, abort_o and rsp_ready_o are all low.
- R2: Status bit positions are: bit 0 output full, bit 1 input full, bit 2 marker flag, bit 3 busy (command closed, response not yet finished), bit 4 ready for a command, bit 5 ready for data. Bits 7:6 read zero. Bits 4 and 5 are never set together.
- R3: Writing code 0x01 to address 1 from any state opens a frame. It discards any held byte, pulses abort_o for one cycle, and makes the status read 0x20.
- R4: Inside an open frame, a data-port write while input-full is clear sets input-full and presents the byte on cmd_data_o with cmd_valid_o high. The cycle with cmd_ready_i high clears it. A data-port write while input-full is set is dropped, and the held byte is unchanged.
- R5: A data-port write outside an open frame is ignored, and so is any command code other than 0x01, 0x03 and 0x22. Neither changes the status or presents a byte to the engine. Code 0x03 outside an open frame is also ignored.
- R6: Code 0x03 in an open frame with input-full clear raises cmd_end_o for exactly one cycle, in the cycle after the write. The status then reads 0x08, and data-port writes after the 0x03 are ignored.
- R7: A rsp_start_i strobe while busy loads 0x01 into the data port. The status becomes 0x0D (marker, busy and output full).
- R8: Each engine byte accepted on rsp_valid_i/rsp_ready_o appears in the data port with status 0x09. rsp_ready_o is high only while output-full is clear, and a host read of address 0 clears output-full.
- R9: rsp_end_i loads 0x03 with status 0x0D as soon as output-full is clear, waiting for any payload byte still unread. Reading that end marker returns the status to 0x10.
- R10: Code 0x22 from any state makes the next status read exactly 0x10, pulses abort_o, and discards buffered command or response bytes.
- R11: Code 0x03 written while a command byte is still held is deferred. cmd_end_o stays low and the status reads 0x02 until the engine takes the byte, and cmd_end_o rises in the cycle after that.
- R12: Any host read of address 0 clears the marker flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_cs_i | input | 1 | Host access strobe, one access per cycle |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | 1 | 0 = data port, 1 = status/command |
| host_wdata_i | input | DW | Host write byte |
| host_rdata_o | output | DW | Host read byte (combinational) |
| cmd_valid_o | output | 1 | Command byte held for the engine |
| cmd_data_o | output | DW | Command byte |
| cmd_ready_i | input | 1 | Engine takes the command byte |
| cmd_end_o | output | 1 | One-cycle end-of-command strobe |
| abort_o | output | 1 | One-cycle strobe on cancel or frame restart |
| rsp_start_i | input | 1 | Engine start-of-response strobe |
| rsp_valid_i | input | 1 | Response byte offered |
| rsp_data_i | input | DW | Response byte |
| rsp_ready_o | output | 1 | Output buffer can take a response byte |
| rsp_end_i | input | 1 | Engine end-of-response strobe |

## Verification
A wrong frame state shows up in the status byte on the very next host read. A stuck ready or busy bit, or a missing ready-for-data bit, is visible in the cycle after the offending command write. A broken input or output buffer shows up at the engine handshake within one cycle, as a lost, duplicated or overwritten byte, or at the data port as a payload byte read where a marker byte was expected. Deferral faults show up as cmd_end_o rising while a byte is still held, or an end marker overwriting unread payload, one cycle after the triggering strobe.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RSP  = 2'd3
  } frame_st_e;

  localparam logic [7:0] CODE_START  = 8'h01;
  localparam logic [7:0] CODE_EOC    = 8'h03;
  localparam logic [7:0] CODE_CANCEL = 8'h22;

  localparam int unsigned SB_OBF  = 0;
  localparam int unsigned SB_IBF  = 1;
  localparam int unsigned SB_MARK = 2;
  localparam int unsigned SB_BUSY = 3;
  localparam int unsigned SB_RDY  = 4;
  localparam int unsigned SB_IBR  = 5;
  localparam int unsigned STAT_W  = 8;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_cmd_i,
  input  logic [DW-1:0] code_i,
  input  logic          ibf_i,
  input  logic          closed_i,
  input  logic          rsp_start_i,
  output frame_st_e     st_o,
  output logic          flush_o,
  output logic          abort_o,
  output logic          cmd_end_o,
  output logic          data_en_o,
  output logic          rsp_open_o,
  output logic          busy_o,
  output logic          rdy_o
);
  frame_st_e st_q;
  logic      eoc_pend_q;
  logic      abort_q;
  logic      is_start, is_eoc, is_cancel;

  assign is_start  = wr_cmd_i && (code_i == DW'(CODE_START));
  assign is_eoc    = wr_cmd_i && (code_i == DW'(CODE_EOC));
  assign is_cancel = wr_cmd_i && (code_i == DW'(CODE_CANCEL));

  assign flush_o    = is_start || is_cancel;
  assign cmd_end_o  = (st_q == ST_CMD) && eoc_pend_q && !ibf_i;
  assign data_en_o  = (st_q == ST_CMD) && !eoc_pend_q;
  assign rsp_open_o = (st_q == ST_WAIT) && rsp_start_i && !flush_o;
  assign busy_o     = (st_q == ST_WAIT) || (st_q == ST_RSP);
  assign rdy_o      = (st_q == ST_IDLE);
  assign abort_o    = abort_q;
  assign st_o       = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      eoc_pend_q <= 1'b0;
      abort_q    <= 1'b0;
    end else begin
      abort_q <= flush_o;
      if (is_cancel) begin
        st_q       <= ST_IDLE;
        eoc_pend_q <= 1'b0;
      end else if (is_start) begin
        st_q       <= ST_CMD;
        eoc_pend_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_CMD: begin
            if (cmd_end_o) begin
              st_q       <= ST_WAIT;
              eoc_pend_q <= 1'b0;
            end else if (is_eoc) begin
              eoc_pend_q <= 1'b1;
            end
          end
          ST_WAIT: if (rsp_start_i) st_q <= ST_RSP;
          ST_RSP:  if (closed_i) st_q <= ST_IDLE;
          default: ;
        endcase
      end
    end
  end

  // R10
  cancel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_cancel |=> (st_q == ST_IDLE) && !eoc_pend_q && abort_o);

  // R3
  start_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_start && !is_cancel) |=> (st_q == ST_CMD) && abort_o);

  // R6
  end_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_end_o |=> !cmd_end_o);
endmodule

// File: rtl/mbx_inbuf.sv
module mbx_inbuf #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          wr_i,
  input  logic          en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          cmd_ready_i,
  output logic          ibf_o,
  output logic          cmd_valid_o,
  output logic [DW-1:0] cmd_data_o
);
  logic          ibf_q;
  logic [DW-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ibf_q <= 1'b0;
      dat_q <= '0;
    end else if (flush_i) begin
      ibf_q <= 1'b0;
    end else if (ibf_q) begin
      if (cmd_ready_i) ibf_q <= 1'b0;
    end else if (wr_i && en_i) begin
      ibf_q <= 1'b1;
      dat_q <= wdata_i;
    end
  end

  assign ibf_o       = ibf_q;
  assign cmd_valid_o = ibf_q;
  assign cmd_data_o  = dat_q;

  // R4
  hold_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ibf_q && !flush_i && !cmd_ready_i) |=> ibf_q && $stable(dat_q));
endmodule

// File: rtl/mbx_outbuf.sv
module mbx_outbuf
  import mbx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          rd_i,
  input  logic          open_i,
  input  logic          rsp_act_i,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_data_i,
  input  logic          rsp_end_i,
  output logic          rsp_ready_o,
  output logic          obf_o,
  output logic          mark_o,
  output logic          closed_o,
  output logic [DW-1:0] dat_o
);
  logic          obf_q, mark_q, end_pend_q, closing_q;
  logic [DW-1:0] dat_q;

  assign rsp_ready_o = rsp_act_i && !obf_q && !end_pend_q && !closing_q;
  assign closed_o    = rd_i && obf_q && closing_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      obf_q      <= 1'b0;
      mark_q     <= 1'b0;
      end_pend_q <= 1'b0;
      closing_q  <= 1'b0;
      dat_q      <= '0;
    end else if (flush_i) begin
      obf_q      <= 1'b0;
      mark_q     <= 1'b0;
      end_pend_q <= 1'b0;
      closing_q  <= 1'b0;
    end else begin
      if (rd_i) begin
        obf_q  <= 1'b0;
        mark_q <= 1'b0;
        if (obf_q) closing_q <= 1'b0;
      end
      if (rsp_act_i && rsp_end_i && !closing_q) end_pend_q <= 1'b1;
      if (open_i) begin
        dat_q  <= DW'(CODE_START);
        obf_q  <= 1'b1;
        mark_q <= 1'b1;
      end else if (rsp_act_i && !obf_q && !closing_q) begin
        if (rsp_valid_i && !end_pend_q) begin
          dat_q  <= rsp_data_i;
          obf_q  <= 1'b1;
          mark_q <= 1'b0;
        end else if (end_pend_q || rsp_end_i) begin
          dat_q      <= DW'(CODE_EOC);
          obf_q      <= 1'b1;
          mark_q     <= 1'b1;
          closing_q  <= 1'b1;
          end_pend_q <= 1'b0;
        end
      end
    end
  end

  assign obf_o  = obf_q;
  assign mark_o = mark_q;
  assign dat_o  = dat_q;

  // R8
  obf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (obf_q && !rd_i && !flush_i) |=> obf_q && $stable(dat_q));

  // R12
  mark_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !open_i && !flush_i) |=> !mark_q || obf_q);
endmodule

// File: rtl/cmdrsp_mailbox.sv
module cmdrsp_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_cs_i,
  input  logic          host_we_i,
  input  logic          host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  output logic          cmd_valid_o,
  output logic [DW-1:0] cmd_data_o,
  input  logic          cmd_ready_i,
  output logic          cmd_end_o,
  output logic          abort_o,
  input  logic          rsp_start_i,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic          rsp_ready_o,
  input  logic          rsp_end_i
);
  logic              wr_cmd, wr_dat, rd_dat;
  logic              flush, data_en, rsp_open, busy, rdy, ibf, obf, mark, closed;
  logic [DW-1:0]     out_dat;
  logic [STAT_W-1:0] status;
  frame_st_e         st;

  assign wr_cmd = host_cs_i && host_we_i && host_addr_i;
  assign wr_dat = host_cs_i && host_we_i && !host_addr_i;
  assign rd_dat = host_cs_i && !host_we_i && !host_addr_i;

  mbx_ctrl #(.DW(DW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_cmd_i    (wr_cmd),
    .code_i      (host_wdata_i),
    .ibf_i       (ibf),
    .closed_i    (closed),
    .rsp_start_i (rsp_start_i),
    .st_o        (st),
    .flush_o     (flush),
    .abort_o     (abort_o),
    .cmd_end_o   (cmd_end_o),
    .data_en_o   (data_en),
    .rsp_open_o  (rsp_open),
    .busy_o      (busy),
    .rdy_o       (rdy)
  );

  mbx_inbuf #(.DW(DW)) u_inbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .wr_i        (wr_dat),
    .en_i        (data_en),
    .wdata_i     (host_wdata_i),
    .cmd_ready_i (cmd_ready_i),
    .ibf_o       (ibf),
    .cmd_valid_o (cmd_valid_o),
    .cmd_data_o  (cmd_data_o)
  );

  mbx_outbuf #(.DW(DW)) u_outbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .rd_i        (rd_dat),
    .open_i      (rsp_open),
    .rsp_act_i   (st == ST_RSP),
    .rsp_valid_i (rsp_valid_i),
    .rsp_data_i  (rsp_data_i),
    .rsp_end_i   (rsp_end_i),
    .rsp_ready_o (rsp_ready_o),
    .obf_o       (obf),
    .mark_o      (mark),
    .closed_o    (closed),
    .dat_o       (out_dat)
  );

  always_comb begin
    status          = '0;
    status[SB_OBF]  = obf;
    status[SB_IBF]  = ibf;
    status[SB_MARK] = mark;
    status[SB_BUSY] = busy;
    status[SB_RDY]  = rdy;
    status[SB_IBR]  = data_en;
  end

  assign host_rdata_o = host_addr_i ? DW'(status) : out_dat;

  // R2
  rdy_ibr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status[SB_RDY] && status[SB_IBR]));

  // R6
  end_drained_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_end_o |-> !cmd_valid_o);

  // R5
  idle_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy && wr_dat && !cmd_valid_o) |=> !cmd_valid_o);
endmodule

// File: tb/cmdrsp_mailbox_test.sv
module cmdrsp_mailbox_test;
  localparam int DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          host_cs_i = 1'b0, host_we_i = 1'b0, host_addr_i = 1'b0;
  logic [DW-1:0] host_wdata_i = '0;
  logic [DW-1:0] host_rdata_o;
  logic          cmd_valid_o, cmd_end_o, abort_o, rsp_ready_o;
  logic [DW-1:0] cmd_data_o;
  logic          cmd_ready_i = 1'b0, rsp_start_i = 1'b0, rsp_valid_i = 1'b0, rsp_end_i = 1'b0;
  logic [DW-1:0] rsp_data_i = '0;

  always #4 clk_i = ~clk_i;

  cmdrsp_mailbox #(.DW(DW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .host_cs_i(host_cs_i), .host_we_i(host_we_i), .host_addr_i(host_addr_i),
    .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
    .cmd_valid_o(cmd_valid_o), .cmd_data_o(cmd_data_o), .cmd_ready_i(cmd_ready_i),
    .cmd_end_o(cmd_end_o), .abort_o(abort_o),
    .rsp_start_i(rsp_start_i), .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
    .rsp_ready_o(rsp_ready_o), .rsp_end_i(rsp_end_i)
  );

  int tests = 0;
  int fails = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic a, input logic [7:0] d);
    host_cs_i = 1'b1; host_we_i = 1'b1; host_addr_i = a; host_wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    host_cs_i = 1'b0; host_we_i = 1'b0; #1;
  endtask

  task automatic host_rd(input logic a, output logic [7:0] d);
    host_cs_i = 1'b1; host_we_i = 1'b0; host_addr_i = a;
    #1 d = host_rdata_o;
    @(posedge clk_i); @(negedge clk_i);
    host_cs_i = 1'b0; #1;
  endtask

  task automatic status_is(input string req, input logic [7:0] exp);
    logic [7:0] v;
    host_rd(1'b1, v);
    check(req, v, exp);
  endtask

  task automatic data_is(input string req, input logic [7:0] exp);
    logic [7:0] v;
    host_rd(1'b0, v);
    check(req, v, exp);
  endtask

  task automatic step();
    @(posedge clk_i); @(negedge clk_i); #1;
  endtask

  task automatic drain();
    cmd_ready_i = 1'b1; @(posedge clk_i); @(negedge clk_i); cmd_ready_i = 1'b0; #1;
  endtask

  task automatic pulse_start();
    rsp_start_i = 1'b1; @(posedge clk_i); @(negedge clk_i); rsp_start_i = 1'b0; #1;
  endtask

  task automatic pulse_end();
    rsp_end_i = 1'b1; @(posedge clk_i); @(negedge clk_i); rsp_end_i = 1'b0; #1;
  endtask

  task automatic push_rsp(input logic [7:0] d);
    rsp_valid_i = 1'b1; rsp_data_i = d;
    @(posedge clk_i); @(negedge clk_i); rsp_valid_i = 1'b0; #1;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1; #1;

    // R1 reset state
    check("R1 cmd_valid", cmd_valid_o, 0);
    check("R1 cmd_end", cmd_end_o, 0);
    check("R1 abort", abort_o, 0);
    check("R1 rsp_ready", rsp_ready_o, 0);
    status_is("R1 status", 8'h10);

    // R5 / R10: sweep every code except frame start while idle
    for (int c = 0; c < 256; c++) begin
      if (c != 1) begin
        host_wr(1'b1, 8'(c));
        status_is((c == 8'h22) ? "R10 idle cancel" : "R5 code ignored", 8'h10);
      end
    end
    host_wr(1'b0, 8'h5A);
    check("R5 idle data valid", cmd_valid_o, 0);
    status_is("R5 idle data status", 8'h10);

    // Frame sweep over command lengths 1..8
    for (int len = 1; len <= 8; len++) begin
      int plen;
      plen = len - 1;
      host_wr(1'b1, 8'h01);
      check("R3 abort on open", abort_o, 1);
      status_is("R3 open status", 8'h20);
      for (int i = 0; i < len; i++) begin
        logic [7:0] b;
        b = 8'(len * 17 + i * 5 + 3);
        host_wr(1'b0, b);
        check("R4 valid", cmd_valid_o, 1);
        check("R4 data", cmd_data_o, b);
        if (i == 0) begin
          host_wr(1'b0, ~b);
          check("R4 overrun dropped", cmd_data_o, b);
        end
        status_is("R2 ibf+ibr", 8'h22);
        if (i < len - 1 || len % 2 == 0) begin
          drain();
          check("R4 drained", cmd_valid_o, 0);
        end
      end
      if (len % 2 == 0) begin
        host_wr(1'b1, 8'h03);
        check("R6 end strobe", cmd_end_o, 1);
        host_wr(1'b0, 8'hEE);
        check("R6 end one cycle", cmd_end_o, 0);
        check("R6 late data ignored", cmd_valid_o, 0);
        status_is("R6 busy status", 8'h08);
      end else begin
        host_wr(1'b1, 8'h03);
        check("R11 end held", cmd_end_o, 0);
        status_is("R11 deferred status", 8'h02);
        drain();
        check("R11 end after drain", cmd_end_o, 1);
        step();
        check("R11 end one cycle", cmd_end_o, 0);
        status_is("R11 busy status", 8'h08);
      end

      pulse_start();
      status_is("R7 start marker status", 8'h0D);
      data_is("R7 start code", 8'h01);
      status_is("R12 marker cleared", 8'h08);
      check("R8 ready when empty", rsp_ready_o, 1);
      for (int j = 0; j < plen; j++) begin
        logic [7:0] p;
        p = 8'(len * 31 + j * 7 + 1);
        push_rsp(p);
        status_is("R8 payload status", 8'h09);
        check("R8 ready low when full", rsp_ready_o, 0);
        if (len == 6 && j == plen - 1) begin
          pulse_end();
          status_is("R9 end waits for read", 8'h09);
          data_is("R8 payload byte", p);
          status_is("R9 end not yet loaded", 8'h08);
        end else begin
          data_is("R8 payload byte", p);
          status_is("R8 cleared on read", 8'h08);
        end
      end
      if (len != 6) pulse_end();
      status_is("R9 end marker status", 8'h0D);
      data_is("R9 end code", 8'h03);
      status_is("R9 back to ready", 8'h10);
    end

    // R3 restart without cancel
    host_wr(1'b1, 8'h01);
    host_wr(1'b0, 8'h11);
    host_wr(1'b1, 8'h01);
    check("R3 restart abort", abort_o, 1);
    check("R3 restart flush", cmd_valid_o, 0);
    status_is("R3 restart status", 8'h20);
    host_wr(1'b0, 8'h22);
    check("R3 accepts after restart", cmd_data_o, 8'h22);
    status_is("R3 ibf after restart", 8'h22);

    // R10 cancel with a byte held
    host_wr(1'b1, 8'h22);
    check("R10 abort", abort_o, 1);
    check("R10 flush cmd", cmd_valid_o, 0);
    status_is("R10 status", 8'h10);

    // R10 cancel during a response
    host_wr(1'b1, 8'h01);
    host_wr(1'b1, 8'h03);
    step();
    pulse_start();
    status_is("R7 start marker again", 8'h0D);
    host_wr(1'b1, 8'h22);
    check("R10 rsp ready low", rsp_ready_o, 0);
    status_is("R10 status mid response", 8'h10);

    summary();
    $finish;
  end
endmodule